// File: doc/BRIEF.md
# Local Interrupt Countdown Timer

This block is a 32-bit down-counter that raises a fixed-delivery interrupt vector when it runs out. Software sets it up through a 32-bit register port. It writes a start value, a clock-divide setting, and a timer entry that holds the vector, a mask bit and a one-shot/periodic mode bit. The count is clocked by an enable input that is first prescaled by a power-of-two divider. When the count expires, the block emits a single-cycle strobe carrying the vector, which goes to the interrupt tracker.

In periodic mode the timer reloads from the start value and keeps running. In one-shot mode it parks at zero. A start value of zero stops the timer completely.

Top module: `irq_countdown_timer`

## Requirements
- R1: After reset the timer entry reads 0x00010000 (masked, vector 0, one-shot), the start count, current count and divide setting all read 0, and no strobe is raised.
- R2: A write to the start-count register (offset 0x380) loads the value into both the start count and the current count (offset 0x390). A write to the current count changes only the current count.
- R3: While the start count is 0 the current count does not change on ticks and no strobe is raised.
- R4: The divide code is register bits {3,1,0}: codes 0..6 divide by 2^(code+1) and code 7 divides by 1. A divided tick occurs on an enabled cycle in which the low `shift` bits of a free-running count of enabled cycles are all ones. Each divided tick lowers an active current count by one.
- R5: When a divided tick finds the current count at 1 (or at 0 in periodic mode), the block raises `raise_vld` for exactly one cycle in the next cycle, with `raise_vec` equal to the entry vector (bits 7:0 at offset 0x320).
- R6: Entry bit 17 selects periodic mode. On expiry, periodic mode reloads the current count from the start count. One-shot mode leaves the count at 0 and then stays idle.
- R7: When entry bit 16 (mask) is set, an expiry updates the count as usual but raises no strobe.
- R8: A count-register write in the same cycle as a divided tick takes the written value, and that cycle produces no expiry.
- R9: Reads return the entry as bits 7:0, 16 and 17, and the divide setting as bits 3, 1 and 0 (offset 0x3E0), with every other bit 0. Reads of any other offset return 0, and writes to any other offset change nothing.
- R10: A cycle with `tick_en` low neither advances the prescaler nor changes the count.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rst_n | input | 1 | Synchronous active-low reset |
| tick_en | input | 1 | Clock enable feeding the prescaler |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 12 | Register byte offset for read and write |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data for `reg_addr`, combinational |
| raise_vld | output | 1 | One-cycle interrupt raise strobe |
| raise_vec | output | 8 | Vector carried by the strobe |

## Verification
The bench goes after the expiry boundary. A timer that raised on reaching 0 instead of on the tick that leaves 1 would fire one tick late, and a periodic reload off by one would drift the period. It goes after the one-shot park: a design that kept decrementing would wrap to 0xFFFFFFFF and fire again billions of ticks later. It also checks that a zero start count stops the timer even after a direct write to the current count, since a design that ignored this would raise from the stale count. It mixes write-versus-tick collisions, mask flips and divide changes under random enables, so that a wrong divide decode or a wrong write priority shows up as an early, late or missing strobe.

// File: rtl/ict_pkg.sv
// Shared constants and helpers for the countdown timer.
// Assumes a 12-bit byte offset register space with 32-bit registers.
package ict_pkg;
    localparam int ADDR_W  = 12;
    localparam int DATA_W  = 32;
    localparam int VEC_W   = 8;
    localparam int SHIFT_W = 3;
    localparam int PRE_W   = 7;

    localparam logic [ADDR_W-1:0] OFF_ENTRY = 12'h320;
    localparam logic [ADDR_W-1:0] OFF_START = 12'h380;
    localparam logic [ADDR_W-1:0] OFF_CUR   = 12'h390;
    localparam logic [ADDR_W-1:0] OFF_DIV   = 12'h3E0;

    localparam int BIT_MASK = 16;
    localparam int BIT_PER  = 17;

    // Map the three-bit divide code to a right-shift amount.
    function automatic logic [SHIFT_W-1:0] code_to_shift(input logic [2:0] code);
        return (code == 3'b111) ? SHIFT_W'(0) : SHIFT_W'(code + 3'd1);
    endfunction
endpackage

// File: rtl/ict_prescaler.sv
// Power-of-two prescaler: counts enabled cycles and emits a divided tick
// whenever the low `shift` bits of that count are all ones.
// Assumes shift never exceeds PRE_W.
module ict_prescaler #(
    parameter int PRE_W   = 7,
    parameter int SHIFT_W = 3
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               tick_en,
    input  logic [SHIFT_W-1:0] shift,
    output logic               div_tick
);
    logic [PRE_W-1:0] pre_q;
    logic [PRE_W-1:0] low_mask;

    // Build the mask of bits that must be all ones for a tick.
    always_comb low_mask = (PRE_W'(1) << shift) - PRE_W'(1);

    // Raise a divided tick on an enabled cycle at the end of a period.
    always_comb div_tick = tick_en && ((pre_q & low_mask) == low_mask);

    // Free-running count of enabled cycles.
    always_ff @(posedge clk) begin
        if (!rst_n)       pre_q <= '0;
        else if (tick_en) pre_q <= pre_q + PRE_W'(1);
    end

    // R4: with a divider above one, two ticks never come back to back
    assert_tick_spacing_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (div_tick && shift != '0) |=> !(div_tick && $stable(shift)));

    // R10: the prescaler holds while the enable is low
    assert_pre_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
        !tick_en |=> $stable(pre_q));
endmodule

// File: rtl/ict_counter.sv
// Start/current count pair with expiry detection and raise strobe.
// Assumes count writes are pre-decoded; a write beats a tick in the same cycle.
module ict_counter #(
    parameter int DATA_W = 32,
    parameter int VEC_W  = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              div_tick,
    input  logic              wr_start,
    input  logic              wr_cur,
    input  logic [DATA_W-1:0] wdata,
    input  logic              periodic,
    input  logic              mask,
    input  logic [VEC_W-1:0]  vec,
    output logic [DATA_W-1:0] start_q,
    output logic [DATA_W-1:0] cur_q,
    output logic              raise_vld,
    output logic [VEC_W-1:0]  raise_vec
);
    logic active;
    logic at_end;
    logic expire;

    // The timer runs only with a nonzero start and, in one-shot mode, a nonzero count.
    always_comb active = (start_q != '0) && (periodic || cur_q != '0);

    // The count is on its last step when it is 1 (or 0 after a direct write).
    always_comb at_end = (cur_q <= DATA_W'(1));

    // An expiry needs a tick, an active timer, and no count write that cycle.
    always_comb expire = div_tick && active && at_end && !wr_start && !wr_cur;

    // Count registers: writes first, then tick-driven decrement or reload.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            start_q <= '0;
            cur_q   <= '0;
        end else if (wr_start) begin
            start_q <= wdata;
            cur_q   <= wdata;
        end else if (wr_cur) begin
            cur_q <= wdata;
        end else if (div_tick && active) begin
            if (at_end) cur_q <= periodic ? start_q : '0;
            else        cur_q <= cur_q - DATA_W'(1);
        end
    end

    // Strobe register: one cycle per unmasked expiry.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            raise_vld <= 1'b0;
            raise_vec <= '0;
        end else begin
            raise_vld <= expire && !mask;
            if (expire) raise_vec <= vec;
        end
    end

    // R3: a zero start freezes the count and raises nothing
    assert_idle_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (start_q == '0 && !wr_start && !wr_cur) |=> ($stable(cur_q) && !raise_vld));

    // R5: every strobe follows a divided tick
    assert_strobe_tick_R5: assert property (@(posedge clk) disable iff (!rst_n)
        raise_vld |-> $past(div_tick));

    // R6: a one-shot timer parked at zero stays there silently
    assert_oneshot_park_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (!periodic && cur_q == '0 && !wr_start && !wr_cur) |=> (cur_q == '0 && !raise_vld));

    // R6: a periodic strobe comes with the count reloaded
    assert_reload_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (raise_vld && $past(periodic)) |-> (cur_q == start_q));

    // R7: no strobe when the entry was masked
    assert_masked_R7: assert property (@(posedge clk) disable iff (!rst_n)
        raise_vld |-> !$past(mask));
endmodule

// File: rtl/irq_countdown_timer.sv
// Top of the countdown timer: register decode, entry and divide storage,
// prescaler and counter. Reads are combinational on reg_addr.
// Assumes only fixed delivery; the raise strobe is not held.
module irq_countdown_timer
    import ict_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              tick_en,
    input  logic              reg_wr,
    input  logic [11:0]       reg_addr,
    input  logic [31:0]       reg_wdata,
    output logic [31:0]       reg_rdata,
    output logic              raise_vld,
    output logic [7:0]        raise_vec
);
    logic [VEC_W-1:0]   ent_vec;
    logic               ent_mask;
    logic               ent_per;
    logic [2:0]         div_code;
    logic [SHIFT_W-1:0] shift;
    logic               div_tick;
    logic [DATA_W-1:0]  start_q;
    logic [DATA_W-1:0]  cur_q;
    logic               wr_entry, wr_start, wr_cur, wr_div;

    // Decode register writes by offset.
    always_comb begin
        wr_entry = reg_wr && (reg_addr == OFF_ENTRY);
        wr_start = reg_wr && (reg_addr == OFF_START);
        wr_cur   = reg_wr && (reg_addr == OFF_CUR);
        wr_div   = reg_wr && (reg_addr == OFF_DIV);
    end

    // Timer entry and divide configuration storage.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ent_vec  <= '0;
            ent_mask <= 1'b1;
            ent_per  <= 1'b0;
            div_code <= 3'b000;
        end else begin
            if (wr_entry) begin
                ent_vec  <= reg_wdata[VEC_W-1:0];
                ent_mask <= reg_wdata[BIT_MASK];
                ent_per  <= reg_wdata[BIT_PER];
            end
            if (wr_div) div_code <= {reg_wdata[3], reg_wdata[1], reg_wdata[0]};
        end
    end

    // Turn the divide code into a shift amount.
    always_comb shift = code_to_shift(div_code);

    ict_prescaler #(.PRE_W(PRE_W), .SHIFT_W(SHIFT_W)) u_pre (
        .clk      (clk),
        .rst_n    (rst_n),
        .tick_en  (tick_en),
        .shift    (shift),
        .div_tick (div_tick)
    );

    ict_counter #(.DATA_W(DATA_W), .VEC_W(VEC_W)) u_cnt (
        .clk       (clk),
        .rst_n     (rst_n),
        .div_tick  (div_tick),
        .wr_start  (wr_start),
        .wr_cur    (wr_cur),
        .wdata     (reg_wdata),
        .periodic  (ent_per),
        .mask      (ent_mask),
        .vec       (ent_vec),
        .start_q   (start_q),
        .cur_q     (cur_q),
        .raise_vld (raise_vld),
        .raise_vec (raise_vec)
    );

    // Read multiplexer; unmapped offsets and unused bits read zero.
    always_comb begin
        reg_rdata = '0;
        case (reg_addr)
            OFF_ENTRY: begin
                reg_rdata[VEC_W-1:0] = ent_vec;
                reg_rdata[BIT_MASK]  = ent_mask;
                reg_rdata[BIT_PER]   = ent_per;
            end
            OFF_START: reg_rdata = start_q;
            OFF_CUR:   reg_rdata = cur_q;
            OFF_DIV: begin
                reg_rdata[3] = div_code[2];
                reg_rdata[1] = div_code[1];
                reg_rdata[0] = div_code[0];
            end
            default:   reg_rdata = '0;
        endcase
    end

    // R8: a current-count write lands as written, whatever the tick did
    assert_write_wins_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_wr && reg_addr == OFF_CUR) |=> (cur_q == $past(reg_wdata) && !raise_vld));
endmodule

// File: tb/irq_countdown_timer_test.sv
module irq_countdown_timer_test;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        tick_en = 1'b0;
    logic        reg_wr = 1'b0;
    logic [11:0] reg_addr = '0;
    logic [31:0] reg_wdata = '0;
    logic [31:0] reg_rdata;
    logic        raise_vld;
    logic [7:0]  raise_vec;

    int tests = 0;
    int fails = 0;
    bit done = 0;

    // bench model state
    logic [7:0]  m_vec;
    logic        m_mask, m_per;
    logic [2:0]  m_code;
    logic [31:0] m_start, m_cur;
    logic [6:0]  m_pre;
    logic        m_raise;
    logic [7:0]  m_rvec;

    always #4 clk = ~clk;

    irq_countdown_timer uut (
        .clk(clk), .rst_n(rst_n), .tick_en(tick_en), .reg_wr(reg_wr),
        .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
        .raise_vld(raise_vld), .raise_vec(raise_vec)
    );

    task automatic check(input string req, input logic [31:0] got, input logic [31:0] exp);
        tests++;
        if (got !== exp) begin
            fails++;
            $display("FAIL %s: got 0x%08h expected 0x%08h", req, got, exp);
        end
    endtask

    function automatic int shift_of(input logic [2:0] c);
        return (c == 3'b111) ? 0 : int'(c) + 1;
    endfunction

    function automatic logic [31:0] model_read(input logic [11:0] a);
        case (a)
            12'h320: return {14'd0, m_per, m_mask, 8'd0, m_vec};
            12'h380: return m_start;
            12'h390: return m_cur;
            12'h3E0: return {28'd0, m_code[2], 1'b0, m_code[1], m_code[0]};
            default: return 32'd0;
        endcase
    endfunction

    task automatic model_reset();
        m_vec = 0; m_mask = 1; m_per = 0; m_code = 0;
        m_start = 0; m_cur = 0; m_pre = 0; m_raise = 0; m_rvec = 0;
    endtask

    // Advance the model by one clock using the inputs now on the pins.
    task automatic model_step();
        logic [6:0] lm;
        logic tick, active, expire;
        lm = 7'((1 << shift_of(m_code)) - 1);
        tick = tick_en && ((m_pre & lm) == lm);
        active = (m_start != 0) && (m_per || m_cur != 0);
        expire = 0;
        if (reg_wr && reg_addr == 12'h380) begin m_start = reg_wdata; m_cur = reg_wdata; end
        else if (reg_wr && reg_addr == 12'h390) m_cur = reg_wdata;
        else if (tick && active) begin
            if (m_cur <= 1) begin expire = 1; m_cur = m_per ? m_start : 0; end
            else m_cur = m_cur - 1;
        end
        m_raise = expire && !m_mask;
        if (expire) m_rvec = m_vec;
        if (reg_wr && reg_addr == 12'h320) begin
            m_vec = reg_wdata[7:0]; m_mask = reg_wdata[16]; m_per = reg_wdata[17];
        end
        if (reg_wr && reg_addr == 12'h3E0) m_code = {reg_wdata[3], reg_wdata[1], reg_wdata[0]};
        if (tick_en) m_pre = m_pre + 1;
    endtask

    // One clock: drive at negedge, update model, compare after the edge.
    task automatic step(input string req, input logic en, input logic wr,
                        input logic [11:0] a, input logic [31:0] d);
        @(negedge clk);
        tick_en = en; reg_wr = wr; reg_addr = a; reg_wdata = d;
        model_step();
        @(posedge clk); #1;
        check(req, {31'd0, raise_vld}, {31'd0, m_raise});
        if (m_raise) check(req, {24'd0, raise_vec}, {24'd0, m_rvec});
        check(req, reg_rdata, model_read(reg_addr));
    endtask

    task automatic peek(input string req, input logic [11:0] a, input logic [31:0] exp);
        @(negedge clk);
        tick_en = 0; reg_wr = 0; reg_addr = a;
        model_step();
        #1;
        check(req, reg_rdata, exp);
    endtask

    initial begin : watchdog
        repeat (150000) @(posedge clk);
        if (!done) begin
            tests++; fails++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("  [TB] %0d tests run, %0d failed", tests, fails);
            $finish;
        end
    end

    initial begin : main
        int seed;
        seed = 1234;
        void'($urandom(seed));
        model_reset();
        repeat (3) @(posedge clk);
        @(negedge clk); rst_n = 1;
        #1;
        // R1 reset values
        peek("R1", 12'h320, 32'h0001_0000);
        peek("R1", 12'h380, 32'h0);
        peek("R1", 12'h390, 32'h0);
        peek("R1", 12'h3E0, 32'h0);
        check("R1", {31'd0, raise_vld}, 32'd0);

        // R9 readback masking: write all ones, only defined bits return
        step("R9", 0, 1, 12'h320, 32'hFFFF_FF5A);
        peek("R9", 12'h320, 32'h0003_005A);
        step("R9", 0, 1, 12'h3E0, 32'hFFFF_FFFF);
        peek("R9", 12'h3E0, 32'h0000_000B);
        step("R9", 0, 1, 12'h3F0, 32'h1234_5678);
        peek("R9", 12'h3F0, 32'h0);
        peek("R9", 12'h380, 32'h0);

        // R3 zero start: direct count write, ticks, no change
        step("R3", 0, 1, 12'h390, 32'd7);
        for (int i = 0; i < 10; i++) step("R3", 1, 0, 12'h390, 0);
        peek("R3", 12'h390, 32'd7);
        check("R3", {31'd0, raise_vld}, 32'd0);

        // R2 start write loads both counts; R5 one-shot expiry at divide 1
        step("R2", 0, 1, 12'h320, 32'h0000_0042);
        step("R2", 0, 1, 12'h380, 32'd3);
        peek("R2", 12'h390, 32'd3);
        peek("R2", 12'h380, 32'd3);
        step("R5", 1, 0, 12'h390, 0);
        step("R5", 1, 0, 12'h390, 0);
        step("R5", 1, 0, 12'h390, 0);
        check("R5", {31'd0, raise_vld}, 32'd1);
        check("R5", {24'd0, raise_vec}, 32'h42);
        // R6 one-shot parks at zero
        for (int i = 0; i < 6; i++) begin
            step("R6", 1, 0, 12'h390, 0);
            check("R6", {31'd0, raise_vld}, 32'd0);
        end
        peek("R6", 12'h390, 32'd0);

        // R6 periodic reload, R7 masked expiry, R10 enable low
        step("R6", 0, 1, 12'h320, 32'h0002_0011);
        step("R6", 0, 1, 12'h380, 32'd4);
        for (int i = 0; i < 12; i++) step("R6", 1, 0, 12'h390, 0);
        step("R7", 0, 1, 12'h320, 32'h0003_0011);
        for (int i = 0; i < 12; i++) begin
            step("R7", 1, 0, 12'h390, 0);
            check("R7", {31'd0, raise_vld}, 32'd0);
        end
        for (int i = 0; i < 8; i++) step("R10", 0, 0, 12'h390, 0);

        // R4 each divide code with periodic expiry
        step("R4", 0, 1, 12'h320, 32'h0002_0077);
        for (int c = 0; c < 8; c++) begin
            step("R4", 0, 1, 12'h3E0, {28'd0, 1'(c >> 2), 1'b0, 2'(c)});
            step("R4", 0, 1, 12'h380, 32'd2);
            for (int i = 0; i < 300; i++) step("R4", 1, 0, 12'h390, 0);
        end

        // R8 count write collides with the expiring tick
        step("R8", 0, 1, 12'h3E0, 32'h0000_000B);
        step("R8", 0, 1, 12'h380, 32'd1);
        step("R8", 1, 1, 12'h390, 32'd9);
        check("R8", {31'd0, raise_vld}, 32'd0);
        peek("R8", 12'h390, 32'd9);

        // R5 R6 R7 R8 R9 R10 random mix
        for (int i = 0; i < 8000; i++) begin
            int r;
            logic [11:0] a;
            logic [31:0] d;
            logic w;
            r = int'($urandom_range(0, 99));
            w = 0; d = 0;
            case ($urandom_range(0, 4))
                0: a = 12'h320; 1: a = 12'h380; 2: a = 12'h390;
                3: a = 12'h3E0; default: a = 12'h3F0;
            endcase
            if (r < 2) begin w = 1; a = 12'h380; d = $urandom_range(0, 12); end
            else if (r < 3) begin w = 1; a = 12'h390; d = $urandom_range(0, 6); end
            else if (r < 5) begin w = 1; a = 12'h320; d = $urandom; end
            else if (r < 6) begin w = 1; a = 12'h3E0; d = $urandom; end
            else if (r < 7) begin w = 1; a = 12'h3F0; d = $urandom; end
            step("R5 R6 R7 R8 R9 R10", ($urandom_range(0, 9) < 7), w, a, d);
        end

        done = 1;
        $display("  [TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end
endmodule